// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands one multiplier bit per clock. A single double-width accumulator holds the running partial product in its upper half and the not-yet-consumed multiplier bits in its lower half. The multiplicand sits in a fixed register and never shifts. In each iteration, when the accumulator's least significant bit is set, the multiplicand is added into the upper half. The whole accumulator then moves one place to the right, and the adder's carry-out enters at the top.

A client raises `start` for one cycle while the block is idle, with the operands presented on the same cycle. The block loads on that edge and raises `busy` for exactly `W` cycles. It then drops `busy` and pulses `done` for one cycle, with the full `2*W`-bit product on `product`. The product holds until the next accepted start. No overflow flag is produced. Deciding whether the result fits in `W` bits is left to the consumer.

Top module: `shift_add_mult`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 loads the block. On the next cycle `busy` is 1, the upper `W` bits of `product` are 0 and the lower `W` bits equal the multiplier operand `mplier_in`.
- R3: Each busy cycle performs one iteration. If `product` bit 0 is 1, `mcand_in` (as captured at start) is added to the upper half, and the `W+1`-bit sum with carry replaces bits `2W-1..W-1` of the shifted value. Otherwise the register shifts right by one with a 0 entering bit `2W-1`. After the first iteration `product` equals `({mcand, mplier} >> 1)` when `mplier[0]` is 1, and `mplier >> 1` otherwise.
- R4: `busy` stays high for exactly `W` consecutive cycles after the load. `done` is a one-cycle pulse in the cycle where `busy` first reads 0 again.
- R5: When `done` is 1, `product` equals the full unsigned `2W`-bit product of the two loaded operands, with no carry lost (for example all-ones operands).
- R6: A `start` sampled while `busy` is 1 is ignored. The running result and the completion cycle are unchanged.
- R7: A zero operand still takes the full `W` iterations and gives a product of zero.
- R8: While idle with no `start`, `product` holds its last value.
- R9: A `start` in the cycle where `done` is 1 is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiply; honoured only when idle |
| mcand_in | input | W | Multiplicand, sampled with an accepted start |
| mplier_in | input | W | Multiplier, sampled with an accepted start |
| busy | output | 1 | High during the W iteration cycles |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*W | Accumulator; the full product when done |

## Verification
The bench builds two instances: one at the default width of 32 and one at a width of 4. The 32-bit instance exposes the longest carry chain, with all-ones operands, single high bits and the cycle-exact busy window. The 4-bit instance is small enough to run every pair of operands, which covers every carry-in and carry-out pattern of the narrow adder. Stray starts in mid-run and back-to-back starts on the done cycle are driven on the wide instance.

// File: rtl/mul_pkg.sv
// Package: shared types for the shift-add multiplier.
// Assumes nothing beyond a two-state sequencer.
package mul_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_t;
endpackage

// File: rtl/mul_adder.sv
// Module: mul_adder
// Adds an optionally gated W-bit addend to a W-bit value and returns the
// W+1-bit sum, with the carry as the top bit. Purely combinational.
module mul_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] addend,
    input  logic         add_en,
    output logic [W:0]   sum
);
    // gated addition: when add_en is low the addend contributes zero
    always_comb begin
        sum = {1'b0, acc_hi} + {1'b0, (add_en ? addend : {W{1'b0}})};
    end
endmodule

// File: rtl/mul_ctrl.sv
// Module: mul_ctrl
// Sequencer: accepts a start only when idle, counts exactly W iteration
// cycles and pulses done once. Assumes start is sampled synchronously.
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    mul_state_t       state;
    logic [CNT_W-1:0] iter;

    // decode of the current state into datapath strobes
    always_comb begin
        busy = (state == ST_RUN);
        step = busy;
        load = (state == ST_IDLE) && start;
    end

    // state, iteration counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            iter  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        iter  <= '0;
                    end
                end
                ST_RUN: begin
                    if (iter == LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        iter <= iter + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mul_datapath.sv
// Module: mul_datapath
// Holds the fixed multiplicand and the 2W-bit accumulator whose low half
// starts as the multiplier. One conditional add plus right shift per step.
module mul_datapath #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] acc
);
    logic [W-1:0] mcand_q;
    logic [W:0]   sum;

    mul_adder #(.W(W)) u_add (
        .acc_hi (acc[2*W-1:W]),
        .addend (mcand_q),
        .add_en (acc[0]),
        .sum    (sum)
    );

    // operand capture and accumulate-then-shift register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc     <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            acc     <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            acc <= {sum, acc[W-1:1]};
        end
    end
endmodule

// File: rtl/shift_add_mult.sv
// Module: shift_add_mult (top)
// Unsigned W x W multi-cycle multiplier giving a 2W-bit product after W
// iteration cycles. Assumes start is ignored while busy; no overflow flag.
module shift_add_mult #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    logic load;
    logic step;

    mul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mul_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .acc       (product)
    );
endmodule

// File: rtl/mul_chk.sv
// Module: mul_chk
// Property checker for shift_add_mult; observes the top's ports only and
// keeps its own operand copies and busy-length counter.
module mul_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [W-1:0]   mcand_in,
    input logic [W-1:0]   mplier_in,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);
    localparam int CW = $clog2(W) + 2;
    localparam logic [CW-1:0] WLEN = CW'(W);

    logic [CW-1:0] bcnt;
    logic [W-1:0]  a_q;
    logic [W-1:0]  b_q;

    // count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    // keep the operands of the accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (start && !busy) begin
            a_q <= mcand_in;
            b_q <= mplier_in;
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && product == {{W{1'b0}}, $past(mplier_in)}));

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < WLEN));

    // R6: a stray start in mid-run must not restart the window
    p_done_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt == WLEN && !busy));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == ({{W{1'b0}}, a_q} * {{W{1'b0}}, b_q})));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));
endmodule

bind shift_add_mult mul_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .busy      (busy),
    .done      (done),
    .product   (product)
);

// File: tb/tb_shift_add_mult.sv
// Directed bench: a 32-bit instance for the scenarios, a 4-bit one swept
// exhaustively. Inputs change and outputs are read on the falling edge.
module tb_shift_add_mult;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int WN = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [W-1:0]    a = '0;
    logic [W-1:0]    b = '0;
    logic            busy;
    logic            done;
    logic [2*W-1:0]  product;

    logic            start_n = 1'b0;
    logic [WN-1:0]   a_n = '0;
    logic [WN-1:0]   b_n = '0;
    logic            busy_n;
    logic            done_n;
    logic [2*WN-1:0] product_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_add_mult #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand_in(a),
        .mplier_in(b), .busy(busy), .done(done), .product(product));

    shift_add_mult #(.W(WN)) dut_w4 (
        .clk(clk), .rst_n(rst_n), .start(start_n), .mcand_in(a_n),
        .mplier_in(b_n), .busy(busy_n), .done(done_n), .product(product_n));

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
        return {32'b0, x} * {32'b0, y};
    endfunction

    // R1: reset state
    task automatic t_reset();
        chk("R1 busy", {63'b0, busy}, 64'd0);
        chk("R1 done", {63'b0, done}, 64'd0);
        chk("R1 product", product, 64'd0);
    endtask

    // full run with load, first step, window and hold checks (R2 R3 R4 R5 R7 R8)
    task automatic t_run(input logic [31:0] x, input logic [31:0] y);
        logic [63:0] step1;
        a = x; b = y; start = 1'b1;
        tick();
        start = 1'b0;
        chk("R2 busy after load", {63'b0, busy}, 64'd1);
        chk("R2 loaded product", product, {32'b0, y});
        tick();
        step1 = y[0] ? ({x, y} >> 1) : {32'b0, y >> 1};
        chk("R3 first iteration", product, step1);
        for (int i = 2; i < W; i++) tick();
        chk("R4 busy in last cycle", {63'b0, busy}, 64'd1);
        chk("R7 no early done", {63'b0, done}, 64'd0);
        tick();
        chk("R4 done pulse", {62'b0, busy, done}, 64'd1);
        chk("R5 product", product, ref_mul(x, y));
        tick();
        chk("R4 done falls", {63'b0, done}, 64'd0);
        chk("R8 hold", product, ref_mul(x, y));
    endtask

    // R6: start pulses during the run are ignored
    task automatic t_ignore();
        a = 32'hDEAD_BEEF; b = 32'h1234_5678; start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 1; i < W; i++) begin
            if (i == 5 || i == 20) begin a = 32'hFFFF_FFFF; b = 32'h7; start = 1'b1; end
            tick();
            start = 1'b0;
        end
        chk("R6 still busy", {63'b0, busy}, 64'd1);
        tick();
        chk("R6 done on time", {63'b0, done}, 64'd1);
        chk("R6 result unchanged", product, ref_mul(32'hDEAD_BEEF, 32'h1234_5678));
        tick();
    endtask

    // R9: start on the done cycle is accepted
    task automatic t_back2back();
        a = 32'd1000; b = 32'd3000; start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 1; i <= W; i++) tick();
        chk("R9 first done", {63'b0, done}, 64'd1);
        a = 32'h8000_0001; b = 32'hFFFF_0000; start = 1'b1;
        tick();
        start = 1'b0;
        chk("R9 reload busy", {63'b0, busy}, 64'd1);
        chk("R9 reload product", product, {32'b0, 32'hFFFF_0000});
        for (int i = 1; i <= W; i++) tick();
        chk("R9 second result", product, ref_mul(32'h8000_0001, 32'hFFFF_0000));
        tick();
    endtask

    // R5 exhaustive on the narrow instance
    task automatic t_narrow_sweep();
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                a_n = WN'(x); b_n = WN'(y); start_n = 1'b1;
                tick();
                start_n = 1'b0;
                for (int i = 1; i <= WN; i++) tick();
                chk("R5 narrow done", {63'b0, done_n}, 64'd1);
                chk("R5 narrow product", {56'b0, product_n}, 64'(x * y));
            end
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_run(32'd6, 32'd7);
        t_run(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        t_run(32'h8000_0000, 32'h8000_0000);
        t_run(32'd0, 32'hA5A5_A5A5);
        t_run(32'h1357_9BDF, 32'd0);
        t_run(32'h0F0F_F0F0, 32'h3333_CCCD);
        t_ignore();
        t_back2back();
        t_narrow_sweep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule